// File: doc/BRIEF.md
# Two-Step Clock Offset Synchronizer

This block keeps a local nanosecond time counter in a peripheral node aligned with a manager clock. The alignment uses a two-step timestamp exchange. A sync event arrives and the peripheral records its local receive time. A follow-up message later supplies the manager's true departure time for that sync. The peripheral then sends a delay request and records its own departure time, and a delay response returns the manager's arrival time for that request. Every message reaches the block as a one-cycle strobe that carries a sequence number and a captured 64-bit timestamp. The block does not parse frames.

Correction happens in two phases. When the follow-up arrives, the difference between the manager send time and the latched local receive time is added to the counter in one step. After that step, a delay request and response pair measures the round trip on the corrected clock. Half of that round trip, plus a programmable static term for fixed circuit delays, is added in a second step. Each correction is folded into the normal per-cycle increment in the same clock edge, so no count value is repeated or skipped.

Top module: `tsync_corrector`

## Requirements
- R1: During reset, time_now, offset_out, delay_out, locked, seq_err and neg_warn are all zero.
- R2: When neither a follow-up nor a delay response takes effect, time_now advances by exactly step_ns on each clock edge.
- R3: A follow-up whose sequence number matches a pending sync sets offset_out to the 65-bit signed value fup_tx_ts - sync_rx_ts. At that same edge, time_now becomes its previous value + step_ns + that offset, taken modulo 2^64.
- R4: A follow-up with no pending sync has no effect. This includes a second follow-up after the pending sync has already been consumed. time_now advances only by step_ns and offset_out keeps its value.
- R5: A follow-up or delay response whose sequence number differs from the pending one discards the sample. seq_err is high for exactly one cycle, locked drops to 0, the block returns to the unsynchronized phase, and time_now advances only by step_ns.
- R6: After an offset step, a delay response that matches the outstanding delay request sets delay_out to floor((dresp_rx_ts - dreq_tx_ts) / 2). At that edge, time_now becomes its previous value + step_ns + delay_out + static_adj.
- R7: A delay response with no outstanding delay request has no effect on time_now or delay_out.
- R8: A negative round trip clamps delay_out to zero and sets neg_warn. neg_warn then stays set until reset. The step still adds step_ns + static_adj.
- R9: locked rises only at the edge that completes a delay step, and only if an offset step came before it. An offset step alone leaves locked at 0.
- R10: A delay request that arrives before any offset step is ignored, so a response to it has no effect.
- R11: static_adj, a two's-complement value, is added to time_now only at delay steps. It is never added at offset steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_ns | input | 16 | Nanoseconds added to the counter each cycle |
| static_adj | input | 64 | Signed fixed-delay term added at each delay step |
| sync_stb | input | 1 | Sync arrival strobe |
| sync_seq | input | 16 | Sync sequence number |
| sync_rx_ts | input | 64 | Local receive time of the sync |
| fup_stb | input | 1 | Follow-up strobe |
| fup_seq | input | 16 | Follow-up sequence number |
| fup_tx_ts | input | 64 | Manager send time of the sync |
| dreq_stb | input | 1 | Delay request departure strobe |
| dreq_seq | input | 16 | Delay request sequence number |
| dreq_tx_ts | input | 64 | Local send time of the delay request |
| dresp_stb | input | 1 | Delay response strobe |
| dresp_seq | input | 16 | Delay response sequence number |
| dresp_rx_ts | input | 64 | Manager receive time of the delay request |
| time_now | output | 64 | Corrected local time |
| offset_out | output | 65 | Last accepted signed offset |
| delay_out | output | 64 | Last accepted one-way delay |
| locked | output | 1 | Offset and delay steps both completed |
| seq_err | output | 1 | One-cycle sequence mismatch flag |
| neg_warn | output | 1 | Sticky negative round-trip warning |

## Verification
Each result of this block is due at the first rising edge that samples its strobe. The counter value, offset_out, delay_out, locked, seq_err and neg_warn all change at that edge, with no extra pipeline stage. The driver raises a strobe on a falling edge and records time_now at that moment. It lowers the strobe just after the next rising edge and queues the expected values there. The monitor compares them at the following falling edge, half a cycle after the result appears. A check that seq_err has dropped again is queued one edge later.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  typedef enum logic [1:0] {
    PH_FREE   = 2'd0,
    PH_OFFSET = 2'd1,
    PH_LOCKED = 2'd2
  } tsync_phase_t;
endpackage

// File: rtl/tsync_offset_calc.sv
module tsync_offset_calc #(
  parameter int TS_W  = 64,
  parameter int SEQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sync_stb,
  input  logic [SEQ_W-1:0]       sync_seq,
  input  logic [TS_W-1:0]        sync_rx_ts,
  input  logic                   fup_stb,
  input  logic [SEQ_W-1:0]       fup_seq,
  input  logic [TS_W-1:0]        fup_tx_ts,
  output logic                   off_fire,
  output logic                   off_err,
  output logic [TS_W:0]          off_val,
  output logic [TS_W:0]          offset_q
);
  logic             pend_q;
  logic [SEQ_W-1:0] pseq_q;
  logic [TS_W-1:0]  prx_q;

  // A follow-up only sees a sync latched on an earlier edge
  always_comb begin
    off_fire = fup_stb && pend_q && (fup_seq == pseq_q);
    off_err  = fup_stb && pend_q && (fup_seq != pseq_q);
    off_val  = {1'b0, fup_tx_ts} - {1'b0, prx_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      pseq_q   <= '0;
      prx_q    <= '0;
      offset_q <= '0;
    end else begin
      if (sync_stb) begin
        pend_q <= 1'b1;
        pseq_q <= sync_seq;
        prx_q  <= sync_rx_ts;
      end else if (fup_stb && pend_q) begin
        pend_q <= 1'b0;
      end
      if (off_fire) offset_q <= off_val;
    end
  end
endmodule

// File: rtl/tsync_delay_calc.sv
module tsync_delay_calc #(
  parameter int TS_W  = 64,
  parameter int SEQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   arm,
  input  logic                   dreq_stb,
  input  logic [SEQ_W-1:0]       dreq_seq,
  input  logic [TS_W-1:0]        dreq_tx_ts,
  input  logic                   dresp_stb,
  input  logic [SEQ_W-1:0]       dresp_seq,
  input  logic [TS_W-1:0]        dresp_rx_ts,
  output logic                   dly_fire,
  output logic                   dly_err,
  output logic                   dly_neg,
  output logic [TS_W-1:0]        dly_val,
  output logic [TS_W-1:0]        delay_q
);
  logic             out_q;
  logic [SEQ_W-1:0] oseq_q;
  logic [TS_W-1:0]  otx_q;
  logic [TS_W:0]    round_trip;

  always_comb begin
    dly_fire   = dresp_stb && out_q && (dresp_seq == oseq_q);
    dly_err    = dresp_stb && out_q && (dresp_seq != oseq_q);
    round_trip = {1'b0, dresp_rx_ts} - {1'b0, otx_q};
    dly_neg    = round_trip[TS_W];
    dly_val    = dly_neg ? '0 : {1'b0, round_trip[TS_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= 1'b0;
      oseq_q  <= '0;
      otx_q   <= '0;
      delay_q <= '0;
    end else begin
      if (!arm) begin
        out_q <= 1'b0;
      end else if (dreq_stb) begin
        out_q  <= 1'b1;
        oseq_q <= dreq_seq;
        otx_q  <= dreq_tx_ts;
      end else if (dresp_stb && out_q) begin
        out_q <= 1'b0;
      end
      if (dly_fire) delay_q <= dly_val;
    end
  end
endmodule

// File: rtl/tsync_clock.sv
module tsync_clock #(
  parameter int TS_W   = 64,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] step_ns,
  input  logic [TS_W-1:0]   corr,
  output logic [TS_W-1:0]   time_q
);
  logic [TS_W-1:0] step_ext;

  generate
    if (STEP_W < TS_W) begin : g_ext
      assign step_ext = {{(TS_W-STEP_W){1'b0}}, step_ns};
    end else begin : g_trunc
      assign step_ext = step_ns[TS_W-1:0];
    end
  endgenerate

  // Increment and correction share one adder path: atomic update
  always_ff @(posedge clk) begin
    if (rst) time_q <= '0;
    else     time_q <= time_q + step_ext + corr;
  end
endmodule

// File: rtl/tsync_corrector.sv
module tsync_corrector
  import tsync_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int STEP_W = 16,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] step_ns,
  input  logic [TS_W-1:0]   static_adj,
  input  logic              sync_stb,
  input  logic [SEQ_W-1:0]  sync_seq,
  input  logic [TS_W-1:0]   sync_rx_ts,
  input  logic              fup_stb,
  input  logic [SEQ_W-1:0]  fup_seq,
  input  logic [TS_W-1:0]   fup_tx_ts,
  input  logic              dreq_stb,
  input  logic [SEQ_W-1:0]  dreq_seq,
  input  logic [TS_W-1:0]   dreq_tx_ts,
  input  logic              dresp_stb,
  input  logic [SEQ_W-1:0]  dresp_seq,
  input  logic [TS_W-1:0]   dresp_rx_ts,
  output logic [TS_W-1:0]   time_now,
  output logic [TS_W:0]     offset_out,
  output logic [TS_W-1:0]   delay_out,
  output logic              locked,
  output logic              seq_err,
  output logic              neg_warn
);
  tsync_phase_t    phase_q;
  logic            off_fire, off_err, dly_fire, dly_err, dly_neg;
  logic [TS_W:0]   off_val;
  logic [TS_W-1:0] dly_val;
  logic [TS_W-1:0] corr;
  logic            arm;

  assign arm = (phase_q != PH_FREE);

  tsync_offset_calc #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_off (
    .clk(clk), .rst(rst),
    .sync_stb(sync_stb), .sync_seq(sync_seq), .sync_rx_ts(sync_rx_ts),
    .fup_stb(fup_stb), .fup_seq(fup_seq), .fup_tx_ts(fup_tx_ts),
    .off_fire(off_fire), .off_err(off_err), .off_val(off_val),
    .offset_q(offset_out)
  );

  tsync_delay_calc #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_dly (
    .clk(clk), .rst(rst), .arm(arm),
    .dreq_stb(dreq_stb), .dreq_seq(dreq_seq), .dreq_tx_ts(dreq_tx_ts),
    .dresp_stb(dresp_stb), .dresp_seq(dresp_seq), .dresp_rx_ts(dresp_rx_ts),
    .dly_fire(dly_fire), .dly_err(dly_err), .dly_neg(dly_neg),
    .dly_val(dly_val), .delay_q(delay_out)
  );

  // Offset from the sync pair; delay plus static term from the request pair
  always_comb begin
    corr = '0;
    if (off_fire) corr = corr + off_val[TS_W-1:0];
    if (dly_fire) corr = corr + dly_val + static_adj;
  end

  tsync_clock #(.TS_W(TS_W), .STEP_W(STEP_W)) u_clk (
    .clk(clk), .rst(rst), .step_ns(step_ns), .corr(corr), .time_q(time_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_FREE;
      seq_err  <= 1'b0;
      neg_warn <= 1'b0;
    end else begin
      seq_err  <= off_err | dly_err;
      neg_warn <= neg_warn | (dly_fire & dly_neg);
      if (off_err || dly_err)            phase_q <= PH_FREE;
      else if (dly_fire)                 phase_q <= PH_LOCKED;
      else if (off_fire && phase_q != PH_LOCKED) phase_q <= PH_OFFSET;
    end
  end

  assign locked = (phase_q == PH_LOCKED);
endmodule

// File: rtl/tsync_corrector_chk.sv
module tsync_corrector_chk #(
  parameter int TS_W   = 64,
  parameter int STEP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [STEP_W-1:0] step_ns,
  input logic              fup_stb,
  input logic              dresp_stb,
  input logic [TS_W-1:0]   time_now,
  input logic [TS_W-1:0]   delay_out,
  input logic              locked,
  input logic              seq_err,
  input logic              neg_warn
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (time_now == '0 && !locked && !seq_err && !neg_warn));

  p_freerun_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fup_stb) && !$past(dresp_stb)) |->
      time_now == $past(time_now) + TS_W'($past(step_ns)));

  p_err_unlock_r5: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> !locked);

  p_lock_source_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(locked)) |-> $past(dresp_stb));

  p_warn_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(neg_warn)) |-> neg_warn);

  p_warn_clamp_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(neg_warn)) |-> delay_out == '0);
endmodule

bind tsync_corrector tsync_corrector_chk #(.TS_W(TS_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst(rst), .step_ns(step_ns), .fup_stb(fup_stb),
  .dresp_stb(dresp_stb), .time_now(time_now), .delay_out(delay_out),
  .locked(locked), .seq_err(seq_err), .neg_warn(neg_warn)
);

// File: tb/tsync_corrector_test.sv
`timescale 1ns/1ps
module tsync_corrector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] step_ns = 16'd8;
  logic [63:0] static_adj = 64'd3;
  logic        sync_stb = 0, fup_stb = 0, dreq_stb = 0, dresp_stb = 0;
  logic [15:0] sync_seq = 0, fup_seq = 0, dreq_seq = 0, dresp_seq = 0;
  logic [63:0] sync_rx_ts = 0, fup_tx_ts = 0, dreq_tx_ts = 0, dresp_rx_ts = 0;
  logic [63:0] time_now, delay_out;
  logic [64:0] offset_out;
  logic        locked, seq_err, neg_warn;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    int          sel;
    logic [64:0] val;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  tsync_corrector uut (
    .clk(clk), .rst(rst), .step_ns(step_ns), .static_adj(static_adj),
    .sync_stb(sync_stb), .sync_seq(sync_seq), .sync_rx_ts(sync_rx_ts),
    .fup_stb(fup_stb), .fup_seq(fup_seq), .fup_tx_ts(fup_tx_ts),
    .dreq_stb(dreq_stb), .dreq_seq(dreq_seq), .dreq_tx_ts(dreq_tx_ts),
    .dresp_stb(dresp_stb), .dresp_seq(dresp_seq), .dresp_rx_ts(dresp_rx_ts),
    .time_now(time_now), .offset_out(offset_out), .delay_out(delay_out),
    .locked(locked), .seq_err(seq_err), .neg_warn(neg_warn)
  );

  // sel: 0 time, 1 offset, 2 delay, 3 locked, 4 seq_err, 5 neg_warn
  function automatic logic [64:0] pick(int sel);
    case (sel)
      0: return {1'b0, time_now};
      1: return offset_out;
      2: return {1'b0, delay_out};
      3: return {64'd0, locked};
      4: return {64'd0, seq_err};
      default: return {64'd0, neg_warn};
    endcase
  endfunction

  task automatic expect_val(string tag, int sel, logic [64:0] val);
    exp_t e;
    e.tag = tag; e.sel = sel; e.val = val;
    q.push_back(e);
  endtask

  // Monitor: compares queued items half a cycle after the result edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [64:0] act;
      e = q.pop_front();
      act = pick(e.sel);
      checks++;
      if (act !== e.val) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", e.tag, e.sel, act, e.val);
      end
    end
  end

  // kind: 0 sync, 1 follow-up, 2 delay request, 3 delay response
  task automatic fire(input int kind, input logic [15:0] seq, input logic [63:0] ts,
                      output logic [63:0] tb);
    @(negedge clk);
    tb = time_now;
    case (kind)
      0: begin sync_stb = 1; sync_seq = seq; sync_rx_ts = ts; end
      1: begin fup_stb = 1; fup_seq = seq; fup_tx_ts = ts; end
      2: begin dreq_stb = 1; dreq_seq = seq; dreq_tx_ts = ts; end
      default: begin dresp_stb = 1; dresp_seq = seq; dresp_rx_ts = ts; end
    endcase
    @(posedge clk);
    #2;
    sync_stb = 0; fup_stb = 0; dreq_stb = 0; dresp_stb = 0;
  endtask

  initial begin
    logic [63:0] tb, t0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    expect_val("R1", 0, 65'd0); expect_val("R1", 1, 65'd0); expect_val("R1", 2, 65'd0);
    expect_val("R1", 3, 65'd0); expect_val("R1", 4, 65'd0); expect_val("R1", 5, 65'd0);
    @(negedge clk);
    rst = 0;
    // R2 free run over five edges
    @(negedge clk);
    t0 = time_now;
    repeat (4) @(negedge clk);
    @(posedge clk); #2;
    expect_val("R2", 0, {1'b0, t0 + 64'd40});
    // R7 response without request
    fire(3, 16'd4, 64'd999, tb);
    expect_val("R7", 0, {1'b0, tb + 64'd8}); expect_val("R7", 2, 65'd0);
    // R10 request before any offset step
    fire(2, 16'd6, 64'd10, tb);
    fire(3, 16'd6, 64'd90, tb);
    expect_val("R10", 0, {1'b0, tb + 64'd8}); expect_val("R10", 2, 65'd0);
    // R4 follow-up with no sync
    fire(1, 16'd5, 64'd777, tb);
    expect_val("R4", 0, {1'b0, tb + 64'd8}); expect_val("R4", 1, 65'd0);
    // R3 positive offset; static term not applied (R11)
    fire(0, 16'd5, 64'd1000, tb);
    fire(1, 16'd5, 64'd5000, tb);
    expect_val("R3", 1, 65'd4000); expect_val("R11", 0, {1'b0, tb + 64'd4008});
    // R4 repeated follow-up after consumption
    fire(1, 16'd5, 64'd8000, tb);
    expect_val("R4", 0, {1'b0, tb + 64'd8}); expect_val("R4", 1, 65'd4000);
    // R3 negative offset
    fire(0, 16'd7, 64'd9000, tb);
    fire(1, 16'd7, 64'd2000, tb);
    expect_val("R3", 1, -65'sd7000);
    expect_val("R3", 0, {1'b0, tb + 64'd8 - 64'd7000});
    expect_val("R9", 3, 65'd0);
    // R6 delay step, even round trip, locks (R9)
    fire(2, 16'd9, 64'd100, tb);
    fire(3, 16'd9, 64'd350, tb);
    expect_val("R6", 2, 65'd125); expect_val("R6", 0, {1'b0, tb + 64'd8 + 64'd125 + 64'd3});
    expect_val("R9", 3, 65'd1);
    // R6 odd round trip truncates
    fire(2, 16'd10, 64'd1000, tb);
    fire(3, 16'd10, 64'd1251, tb);
    expect_val("R6", 2, 65'd125); expect_val("R6", 0, {1'b0, tb + 64'd136});
    // R8 negative round trip
    fire(2, 16'd11, 64'd500, tb);
    fire(3, 16'd11, 64'd300, tb);
    expect_val("R8", 2, 65'd0); expect_val("R8", 5, 65'd1);
    expect_val("R8", 0, {1'b0, tb + 64'd11});
    // R5 follow-up sequence mismatch
    fire(0, 16'd1, 64'd50, tb);
    fire(1, 16'd2, 64'd60, tb);
    expect_val("R5", 4, 65'd1); expect_val("R5", 3, 65'd0);
    expect_val("R5", 0, {1'b0, tb + 64'd8}); expect_val("R5", 1, -65'sd7000);
    @(posedge clk); #2;
    expect_val("R5", 4, 65'd0); expect_val("R8", 5, 65'd1);
    // R9 offset step alone does not lock
    fire(0, 16'd3, 64'd20, tb);
    fire(1, 16'd3, 64'd30, tb);
    expect_val("R9", 3, 65'd0); expect_val("R3", 1, 65'd10);
    // R5 delay response mismatch after offset step
    fire(2, 16'd12, 64'd0, tb);
    fire(3, 16'd13, 64'd40, tb);
    expect_val("R5", 4, 65'd1); expect_val("R5", 0, {1'b0, tb + 64'd8});
    expect_val("R5", 2, 65'd0);
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule